// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the date as packed BCD counters. A one-cycle tick enable at 128 Hz, made elsewhere from the timebase, drives a 7-bit sub-second counter. Each time that counter wraps, seconds advance by one, and the carry passes up through minutes, hours, weekday, day of month, month, year and, as a build option, a century byte. Every counter and two control registers sit on a byte-wide register port. Writes take effect on the clock edge, and read data comes back registered one cycle after the address.

To set the time, software stops the clock and clears the prescaler with one write to the run-control register. It then loads the counters and sets the enable and start bits. To read the time, software clears the carry flag, reads all the counters, and reads the flag again. If the flag is set, a second boundary fell inside the read and software repeats it. The carry flag can raise an interrupt. A one-shot command rounds the time to the nearest minute.

Top module: `rtc_bcd_core`

## Requirements
- R1: After a synchronous reset, the time reads 00:00:00 on weekday 0 and the date reads month 01, day 01, year 00. The century byte reads 0x20 when the four-digit year is built in. Both control registers, the read data and the interrupt are 0.
- R2: Read data appears one cycle after the address. The offsets are: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year, 8 century, 12 status/interrupt register, 13 run-control register. Every other offset reads 0x00.
- R3: The sub-second counter is a 7-bit binary count. It advances on each tick while the clock runs, and only while both start (run-control bit 0) and enable (run-control bit 3) are 1. Its wrap from 127 to 0 advances seconds by exactly one.
- R4: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each carrying into the next field. The weekday counts 0 to 6 and advances with the day of month.
- R5: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11. It wraps after day 31 in the other months, except month 02, where it wraps after day 28, or after day 29 when the year value is divisible by 4. The month runs from 01 to 12 and wraps to 01, carrying into the year.
- R6: The year byte wraps from 99 to 00. In the four-digit build that wrap advances the century byte, which also wraps from 99 to 00. In the two-digit build, offset 8 reads 0x00 and ignores writes.
- R7: Writes to counter offsets 1 to 8 load the counter only while start is 0. While start is 1 they are ignored. The sub-second counter can never be written.
- R8: While start or enable is 0, ticks advance no counter.
- R9: The carry flag is bit 7 of the status register. It sets on every sub-second wrap. A write to the status register with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R10: The carry interrupt enable is bit 4 of the status register. The interrupt output is registered and is high exactly when the flag and the enable are both 1.
- R11: A write of 1 to run-control bit 1 clears the sub-second counter. This clear beats a tick in the same cycle, and no carry into seconds occurs on that edge. The bit reads back 0.
- R12: A write of 1 to run-control bit 2 sets seconds to 00. It also advances minutes, with the full carry chain, when seconds were 30 or more. It takes priority over a carry into seconds in the same cycle, does not touch the carry flag, and reads back 0.
- R13: The run-control register reads back enable at bit 3 and start at bit 0. Bits 7 to 4, 2 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 128 Hz one-cycle tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's offset |
| irq | output | 1 | Carry interrupt, registered |

## Verification
The bench sets the clock just before month ends in 30-day months, in 31-day months, and in February of leap and non-leap years. It also crosses the year and century wraps. A wrong month-length table shows up as a date such as April 31 or a skipped February 29. The bench lines up control writes to land on the exact sub-second wrap edge. A design that lets the flag clear win would lose a rollover. One that lets the prescaler clear lose to the tick would insert a second, and one that lets the carry beat the adjust would leave seconds at 01. Writes aimed at counters while the clock runs, and at the read-only sub-second counter, catch a missing write lock. A design that forgets the 30-second threshold would leave minutes unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned OFS_SUB  = 0;
  localparam int unsigned OFS_SEC  = 1;
  localparam int unsigned OFS_MIN  = 2;
  localparam int unsigned OFS_HOUR = 3;
  localparam int unsigned OFS_WDAY = 4;
  localparam int unsigned OFS_MDAY = 5;
  localparam int unsigned OFS_MON  = 6;
  localparam int unsigned OFS_YEAR = 7;
  localparam int unsigned OFS_CENT = 8;
  localparam int unsigned OFS_STAT = 12;
  localparam int unsigned OFS_RUN  = 13;

  // status register bits
  localparam int unsigned ST_FLAG = 7;
  localparam int unsigned ST_IE   = 4;
  // run-control register bits
  localparam int unsigned RC_EN   = 3;
  localparam int unsigned RC_ADJ  = 2;
  localparam int unsigned RC_CLR  = 1;
  localparam int unsigned RC_GO   = 0;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // a two-digit BCD year is divisible by 4 when (2*tens + units) mod 4 is 0
  function automatic logic leap_yr(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int SUB_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  output logic [SUB_W-1:0] sub,
  output logic             wrap
);

  logic [SUB_W-1:0] sub_q;

  assign wrap = run & tick & ~clr & (&sub_q);
  assign sub  = sub_q;

  always_ff @(posedge clk) begin
    if (rst)              sub_q <= '0;
    else if (clr)         sub_q <= '0;
    else if (run && tick) sub_q <= sub_q + 1'b1;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int AW    = 4,
  parameter bit YEAR4 = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          adj,
  input  logic          ld,
  input  logic [AW-1:0] ld_ofs,
  input  logic [7:0]    ld_val,
  output cal_t          now,
  output logic [7:0]    cent
);

  localparam cal_t CAL_RESET = '{year: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h00,
                                 hour: 8'h00, min: 8'h00, sec: 8'h00};

  cal_t nxt;
  logic c_min, c_hour, c_day, c_mon, c_yr, c_cent;

  always_comb begin
    nxt    = now;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_yr   = 1'b0;
    c_cent = 1'b0;

    if (adj) begin
      nxt.sec = 8'h00;
      c_min   = (now.sec >= 8'h30);
    end else if (step) begin
      if (now.sec == 8'h59) begin
        nxt.sec = 8'h00;
        c_min   = 1'b1;
      end else begin
        nxt.sec = bcd_inc(now.sec);
      end
    end

    if (c_min) begin
      if (now.min == 8'h59) begin
        nxt.min = 8'h00;
        c_hour  = 1'b1;
      end else begin
        nxt.min = bcd_inc(now.min);
      end
    end

    if (c_hour) begin
      if (now.hour == 8'h23) begin
        nxt.hour = 8'h00;
        c_day    = 1'b1;
      end else begin
        nxt.hour = bcd_inc(now.hour);
      end
    end

    if (c_day) begin
      nxt.wday = (now.wday == 8'h06) ? 8'h00 : now.wday + 8'h01;
      if (now.mday == month_len(now.mon, now.year)) begin
        nxt.mday = 8'h01;
        c_mon    = 1'b1;
      end else begin
        nxt.mday = bcd_inc(now.mday);
      end
    end

    if (c_mon) begin
      if (now.mon == 8'h12) begin
        nxt.mon = 8'h01;
        c_yr    = 1'b1;
      end else begin
        nxt.mon = bcd_inc(now.mon);
      end
    end

    if (c_yr) begin
      if (now.year == 8'h99) begin
        nxt.year = 8'h00;
        c_cent   = 1'b1;
      end else begin
        nxt.year = bcd_inc(now.year);
      end
    end

    if (ld) begin
      case (32'(ld_ofs))
        OFS_SEC:  nxt.sec  = ld_val;
        OFS_MIN:  nxt.min  = ld_val;
        OFS_HOUR: nxt.hour = ld_val;
        OFS_WDAY: nxt.wday = ld_val;
        OFS_MDAY: nxt.mday = ld_val;
        OFS_MON:  nxt.mon  = ld_val;
        OFS_YEAR: nxt.year = ld_val;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) now <= CAL_RESET;
    else     now <= nxt;
  end

  generate
    if (YEAR4) begin : g_cent
      logic [7:0] cent_q, cent_d;
      always_comb begin
        cent_d = cent_q;
        if (c_cent) cent_d = (cent_q == 8'h99) ? 8'h00 : bcd_inc(cent_q);
        if (ld && (32'(ld_ofs) == OFS_CENT)) cent_d = ld_val;
      end
      always_ff @(posedge clk) begin
        if (rst) cent_q <= 8'h20;
        else     cent_q <= cent_d;
      end
      assign cent = cent_q;
    end else begin : g_two_digit
      assign cent = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    st_bits,   // {flag, ie} write bits
  input  logic [3:0]    rc_bits,   // {en, adj, clr, go} write bits
  input  logic          wrap,
  output logic          go,
  output logic          en,
  output logic          flag,
  output logic          ie,
  output logic          prst,
  output logic          adj,
  output logic          irq
);

  logic wr_st, wr_rc, flag_d, ie_d;

  assign wr_st = wr_en && (32'(addr) == OFS_STAT);
  assign wr_rc = wr_en && (32'(addr) == OFS_RUN);
  assign prst  = wr_rc && rc_bits[RC_CLR];
  assign adj   = wr_rc && rc_bits[RC_ADJ];

  always_comb begin
    flag_d = flag;
    if (wrap)                   flag_d = 1'b1;
    else if (wr_st && !st_bits[1]) flag_d = 1'b0;
    ie_d = wr_st ? st_bits[0] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go   <= 1'b0;
      en   <= 1'b0;
      flag <= 1'b0;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wr_rc) begin
        go <= rc_bits[RC_GO];
        en <= rc_bits[RC_EN];
      end
      flag <= flag_d;
      ie   <= ie_d;
      irq  <= flag_d & ie_d;
    end
  end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int AW    = 4,
  parameter bit YEAR4 = 1'b1,
  parameter int SUB_W = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);

  logic             go, en, run, flag, ie, prst, adj, wrap;
  logic [SUB_W-1:0] sub_q;
  cal_t             now;
  logic [7:0]       cent;
  logic [7:0]       rd_d;

  assign run = go & en;

  rtc_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .st_bits ({wdata[ST_FLAG], wdata[ST_IE]}),
    .rc_bits (wdata[3:0]),
    .wrap    (wrap),
    .go      (go),
    .en      (en),
    .flag    (flag),
    .ie      (ie),
    .prst    (prst),
    .adj     (adj),
    .irq     (irq)
  );

  rtc_prescaler #(.SUB_W(SUB_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .clr  (prst),
    .sub  (sub_q),
    .wrap (wrap)
  );

  rtc_calendar #(.AW(AW), .YEAR4(YEAR4)) u_cal (
    .clk    (clk),
    .rst    (rst),
    .step   (wrap),
    .adj    (adj),
    .ld     (wr_en & ~go),
    .ld_ofs (addr),
    .ld_val (wdata),
    .now    (now),
    .cent   (cent)
  );

  always_comb begin
    rd_d = 8'h00;
    case (32'(addr))
      OFS_SUB:  rd_d = 8'(sub_q);
      OFS_SEC:  rd_d = now.sec;
      OFS_MIN:  rd_d = now.min;
      OFS_HOUR: rd_d = now.hour;
      OFS_WDAY: rd_d = now.wday;
      OFS_MDAY: rd_d = now.mday;
      OFS_MON:  rd_d = now.mon;
      OFS_YEAR: rd_d = now.year;
      OFS_CENT: rd_d = cent;
      OFS_STAT: begin
        rd_d[ST_FLAG] = flag;
        rd_d[ST_IE]   = ie;
      end
      OFS_RUN: begin
        rd_d[RC_EN] = en;
        rd_d[RC_GO] = go;
      end
      default: rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk
  import rtc_pkg::*;
#(
  parameter int AW    = 4,
  parameter int SUB_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic             run,
  input logic             go,
  input logic             prst,
  input logic             adj,
  input logic [SUB_W-1:0] sub,
  input logic [7:0]       sec,
  input logic             flag,
  input logic             ie,
  input logic             irq
);

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !prst) |=> (sub == $past(sub) + 1'b1)); // R3

  AST_FROZEN_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> ($stable(sec) && $stable(sub))); // R8

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (go && wr_en && (32'(addr) == OFS_SEC) && !(run && tick)) |=> $stable(sec)); // R7

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !prst && (&sub)) |=> flag); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie)); // R10

  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    prst |=> (sub == '0)); // R11

  AST_ADJUST_ZERO: assert property (@(posedge clk) disable iff (rst)
    adj |=> (sec == 8'h00)); // R12

endmodule

bind rtc_bcd_core rtc_bcd_chk #(.AW(AW), .SUB_W(SUB_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick),
  .wr_en (wr_en),
  .addr  (addr),
  .run   (run),
  .go    (go),
  .prst  (prst),
  .adj   (adj),
  .sub   (sub_q),
  .sec   (now.sec),
  .flag  (flag),
  .ie    (ie),
  .irq   (irq)
);

// File: tb/rtc_bcd_core_tb.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb;
  import rtc_pkg::*;

  localparam int AW      = 4;
  localparam bit YEAR4   = 1'b1;
  localparam int SUB_W   = 7;
  localparam int SUB_MAX = (1 << SUB_W) - 1;
  localparam int WD_CYC  = 100000;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  rtc_bcd_core #(.AW(AW), .YEAR4(YEAR4), .SUB_W(SUB_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  int tick_mode = 0;
  int sweep = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state (binary integers)
  int m_sub, m_sec, m_min, m_hr, m_wd, m_md, m_mon, m_yr, m_cen;
  bit m_go, m_en, m_flag, m_ie;
  logic [7:0] exp_rd;
  bit exp_irq;
  bit armed = 0;
  int last_addr = 0;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv_yr();
    if (m_yr == 99) begin
      m_yr = 0;
      m_cen = (m_cen == 99) ? 0 : m_cen + 1;
    end else m_yr++;
  endtask

  task automatic adv_mon();
    if (m_mon == 12) begin m_mon = 1; adv_yr(); end
    else m_mon++;
  endtask

  task automatic adv_day();
    m_wd = (m_wd == 6) ? 0 : m_wd + 1;
    if (m_md == mlen(m_mon, m_yr)) begin m_md = 1; adv_mon(); end
    else m_md++;
  endtask

  task automatic adv_hr();
    if (m_hr == 23) begin m_hr = 0; adv_day(); end
    else m_hr++;
  endtask

  task automatic adv_min();
    if (m_min == 59) begin m_min = 0; adv_hr(); end
    else m_min++;
  endtask

  task automatic adv_sec();
    if (m_sec == 59) begin m_sec = 0; adv_min(); end
    else m_sec++;
  endtask

  task automatic model_reset();
    m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0;
    m_md = 1; m_mon = 1; m_yr = 0; m_cen = 20;
    m_go = 0; m_en = 0; m_flag = 0; m_ie = 0;
  endtask

  function automatic logic [7:0] model_read(input int a);
    case (a)
      0:  return 8'(m_sub);
      1:  return i2b(m_sec);
      2:  return i2b(m_min);
      3:  return i2b(m_hr);
      4:  return i2b(m_wd);
      5:  return i2b(m_md);
      6:  return i2b(m_mon);
      7:  return i2b(m_yr);
      8:  return YEAR4 ? i2b(m_cen) : 8'h00;
      12: return {m_flag, 2'b00, m_ie, 4'b0000};
      13: return {4'b0000, m_en, 2'b00, m_go};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    int a;
    bit w, run, old_go, pclr, adj, wrap;
    a      = int'(addr);
    w      = wr_en;
    run    = m_go && m_en;
    old_go = m_go;
    pclr   = w && (a == 13) && wdata[1];
    adj    = w && (a == 13) && wdata[2];
    wrap   = run && tick && !pclr && (m_sub == SUB_MAX);
    if (pclr) m_sub = 0;
    else if (run && tick) m_sub = (m_sub + 1) % (SUB_MAX + 1);
    if (adj) begin
      bit up;
      up = (m_sec >= 30);
      m_sec = 0;
      if (up) adv_min();
    end else if (wrap) adv_sec();
    if (w && !old_go) begin
      case (a)
        1: m_sec = b2i(wdata);
        2: m_min = b2i(wdata);
        3: m_hr  = b2i(wdata);
        4: m_wd  = b2i(wdata);
        5: m_md  = b2i(wdata);
        6: m_mon = b2i(wdata);
        7: m_yr  = b2i(wdata);
        8: if (YEAR4) m_cen = b2i(wdata);
        default: ;
      endcase
    end
    if (w && a == 13) begin m_go = wdata[0]; m_en = wdata[3]; end
    if (wrap) m_flag = 1;
    else if (w && a == 12 && !wdata[7]) m_flag = 0;
    if (w && a == 12) m_ie = wdata[4];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      exp_rd  = 8'h00;
      exp_irq = 0;
      armed   = 1;
    end else begin
      last_addr = int'(addr);
      exp_rd = model_read(int'(addr));
      model_step();
      exp_irq = m_flag && m_ie;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      n_cmp++;
      if (rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s: rdata at offset %0d act=%02h exp=%02h", phase, last_addr, rdata, exp_rd);
      end
      n_cmp++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL %s: irq act=%0b exp=%0b", phase, irq, exp_irq);
      end
    end
  end

  task automatic cyc(input bit w, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w;
    addr  = w ? AW'(a) : AW'(sweep);
    wdata = w ? d : 8'h00;
    case (tick_mode)
      0: tick = 1'b0;
      1: tick = 1'b1;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick = lfsr[0];
      end
    endcase
    sweep = (sweep + 1) % 16;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 8'h00);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cyc(1'b1, a, d);
  endtask

  // stop, clear prescaler, load every counter, then start
  task automatic set_cal(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                         input logic [7:0] y, input logic [7:0] c);
    wr(13, 8'h02);
    wr(1, s);  wr(2, mi); wr(3, h); wr(4, wd);
    wr(5, md); wr(6, mo); wr(7, y); wr(8, c);
    idle(16);
    wr(13, 8'h09);
  endtask

  initial begin
    // R1 reset state, R2 full offset sweep
    rst = 1'b1;
    idle(4);
    @(negedge clk); rst = 1'b0;
    phase = "R1 R2 R13";
    idle(32);

    tick_mode = 1;
    // R4 R5: non-leap February end, 23:59:58 rolls to next day
    phase = "R4 R5";
    set_cal(8'h58, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h23, 8'h20);
    idle(300);

    // R7: writes while running are ignored, sub-second never writable
    phase = "R7";
    wr(1, 8'h33); idle(3);
    wr(0, 8'h11); idle(3);
    wr(2, 8'h44); idle(3);
    wr(8, 8'h05); idle(16);
    wr(13, 8'h00);
    wr(0, 8'h22); idle(16);

    // R5 leap February and month lengths
    phase = "R5";
    set_cal(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h24, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h07, 8'h24, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h06, 8'h24, 8'h20);
    idle(150);

    // R6 year and century wrap
    phase = "R6";
    set_cal(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99, 8'h20);
    idle(150);
    set_cal(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99, 8'h99);
    idle(150);

    // R8 halted when start or enable is low
    phase = "R8";
    wr(13, 8'h01); idle(300);
    wr(13, 8'h08); idle(300);
    wr(13, 8'h00); idle(40);

    // R9 R10 carry flag, interrupt, set beats clear
    phase = "R9 R10";
    wr(13, 8'h02);
    wr(12, 8'h10);
    wr(13, 8'h09);
    idle(127);
    wr(12, 8'h10);          // clear lands on the wrap edge: flag stays
    idle(5);
    wr(12, 8'h90);          // writing 1 leaves the flag
    idle(5);
    wr(12, 8'h10);          // clears the flag
    idle(5);
    wr(12, 8'h00);          // interrupt disabled
    idle(200);
    wr(12, 8'h90);          // re-enable with flag pending
    idle(10);
    wr(12, 8'h00);
    idle(5);

    // R11 prescaler clear, also on the wrap edge
    phase = "R11";
    idle(40);
    wr(13, 8'h0B); idle(60);
    wr(13, 8'h0B); idle(127);
    wr(13, 8'h0B); idle(20);

    // R12 30-second adjust
    phase = "R12";
    set_cal(8'h29, 8'h10, 8'h08, 8'h02, 8'h15, 8'h05, 8'h24, 8'h20);
    idle(10); wr(13, 8'h0D); idle(20);
    set_cal(8'h45, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h24, 8'h20);
    idle(10); wr(13, 8'h0D); idle(20);
    set_cal(8'h30, 8'h05, 8'h01, 8'h01, 8'h10, 8'h03, 8'h24, 8'h20);
    wr(13, 8'h0B); idle(127);
    wr(13, 8'h0D); idle(20);
    wr(13, 8'h00); wr(1, 8'h31); idle(4);
    wr(13, 8'h04); idle(20);

    // R3 irregular tick pattern with the clock running
    phase = "R3 R4";
    set_cal(8'h50, 8'h59, 8'h22, 8'h00, 8'h27, 8'h02, 8'h28, 8'h20);
    tick_mode = 2;
    idle(3000);

    tick_mode = 0;
    idle(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish (all requirements) act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule